// File: doc/BRIEF.md
# Programmable Transmit Field Unpacker

This block sits between a 32-bit transmit FIFO and a serial shifter. It takes one FIFO word at a time and splits it into a short run of bit fields. Each field is at most 8 bits wide. A bank of four 10-bit micro-operation vectors sets where each field starts in the word, which way it is read, how many bits it holds, and which operation closes the word. The shifter gets each field with its bit count and a flag that marks the last field of the word.

Software loads the vectors through a small write port, two vectors per 32-bit write. It also writes a 2-bit code for the number of protocol words in each entry. The block only reports that code and never decodes it: 0 means four 8-bit words, 1 two 16-bit words, 2 one 32-bit word, and 3 is undefined. The configuration can change only while the block holds no word, so a word is always unpacked under one consistent set of vectors.

Top module: `fifo_field_unpacker`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `gran_code` is 0. The four vectors are the plain byte split: starts 0, 8, 16 and 24, reading upward, length field 7, stop set only on vector 3.
- R2: A vector holds the start position in bits 9:5, the direction in bit 4 (1 reads downward, from the MSB side), the length minus one in bits 3:1 and stop in bit 0. A write with `cfg_sel`=0 loads vector 0 from `cfg_wdata[9:0]` and vector 1 from `cfg_wdata[19:10]`. `cfg_sel`=1 loads vectors 2 and 3 from the same positions, and `cfg_sel`=2 loads the granularity code from `cfg_wdata[1:0]`.
- R3: With direction 1, `out_bits[k]` equals word bit (start − k) for k from 0 to the length field.
- R4: With direction 0, `out_bits[k]` equals word bit (start + k) for k from 0 to the length field.
- R5: `out_len` equals the length field plus one, in the range 1 to 8. Bits of `out_bits` at index `out_len` and above are 0.
- R6: Operations run in order from vector 0. The first one with stop set gives the last field of the word, flagged with `out_last`=1. The next word starts again at vector 0.
- R7: If none of the four vectors has stop set, operation 3 is the last one and carries `out_last`=1.
- R8: `in_ready` is 1 only while no word is held. A word is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the cycle after that.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bits`, `out_len` and `out_last` hold their values.
- R10: A configuration write made while a word is held has no effect, neither on the vectors nor on `gran_code`.
- R11: `gran_code` shows the last granularity code accepted, starting in the cycle after the write.
- R12: A field bit whose position falls below 0 or above 31 is output as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 vectors 0/1, 1 vectors 2/3, 2 granularity |
| cfg_wdata | input | 32 | Configuration write data |
| gran_code | output | 2 | Current granularity code |
| in_valid | input | 1 | FIFO word offered |
| in_ready | output | 1 | Unpacker idle and able to take a word |
| in_word | input | 32 | FIFO word |
| out_valid | output | 1 | Field available |
| out_ready | input | 1 | Shifter takes the field |
| out_bits | output | 8 | Field bits, bit 0 sent first |
| out_len | output | 4 | Number of valid field bits, 1 to 8 |
| out_last | output | 1 | Field is the last of its word |

## Verification
If the operation index is wrong, the next field comes from the wrong vector. That shows at the ports in the cycle after the handshake as a wrong start, length or direction. If the busy flag is wrong, `in_ready` rises during a word, or a word is never released, within one cycle of the fault. If a configuration register is corrupted, it only shows on the next word, in its fields or in a missing `out_last`. The tests therefore run several words in a row under each configuration, and they hold the output back so that writes land while a word is held.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int FU_WORD_W      = 32;
  localparam int FU_FIELD_W     = 8;
  localparam int FU_NUM_OPS     = 4;
  localparam int FU_VECS_PER_REG = 2;
  localparam int FU_START_W     = $clog2(FU_WORD_W);
  localparam int FU_LENM1_W     = $clog2(FU_FIELD_W);
  localparam int FU_LEN_W       = FU_LENM1_W + 1;
  localparam int FU_VEC_W       = FU_START_W + 1 + FU_LENM1_W + 1;
  localparam int FU_NUM_REGS    = FU_NUM_OPS / FU_VECS_PER_REG;
  localparam int FU_SEL_W       = 2;
  localparam int FU_GRAN_W      = 2;
  localparam int FU_GRAN_SEL    = FU_NUM_REGS;
  localparam int FU_OP_W        = $clog2(FU_NUM_OPS);

  typedef struct packed {
    logic [FU_START_W-1:0] start;
    logic                  msb_first;
    logic [FU_LENM1_W-1:0] len_m1;
    logic                  stop;
  } fu_vec_t;

  // Reset program: plain byte split, lowest byte first
  function automatic fu_vec_t fu_default_vec(input int idx);
    fu_vec_t v;
    v.start     = FU_START_W'(idx * FU_FIELD_W);
    v.msb_first = 1'b0;
    v.len_m1    = FU_LENM1_W'(FU_FIELD_W - 1);
    v.stop      = (idx == FU_NUM_OPS - 1);
    return v;
  endfunction
endpackage

// File: rtl/fu_cfg_bank.sv
module fu_cfg_bank
  import fu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          busy,
  input  logic                          cfg_we,
  input  logic [FU_SEL_W-1:0]           cfg_sel,
  input  logic [FU_WORD_W-1:0]          cfg_wdata,
  output logic [FU_NUM_OPS*FU_VEC_W-1:0] vec_flat,
  output logic [FU_GRAN_W-1:0]          gran_q
);
  // Writes are accepted only between words
  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  for (genvar g = 0; g < FU_NUM_OPS; g++) begin : g_vec
    localparam int REG_IDX = g / FU_VECS_PER_REG;
    localparam int SLOT    = g % FU_VECS_PER_REG;
    logic [FU_VEC_W-1:0] vec_q;
    always_ff @(posedge clk) begin
      if (rst)
        vec_q <= fu_default_vec(g);
      else if (wr_ok && cfg_sel == FU_SEL_W'(REG_IDX))
        vec_q <= cfg_wdata[SLOT*FU_VEC_W +: FU_VEC_W];
    end
    assign vec_flat[g*FU_VEC_W +: FU_VEC_W] = vec_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      gran_q <= '0;
    else if (wr_ok && cfg_sel == FU_SEL_W'(FU_GRAN_SEL))
      gran_q <= cfg_wdata[FU_GRAN_W-1:0];
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(vec_flat) && $stable(gran_q))); // R10
endmodule

// File: rtl/fu_field_extract.sv
module fu_field_extract
  import fu_pkg::*;
#(
  parameter int WORD_W  = FU_WORD_W,
  parameter int FIELD_W = FU_FIELD_W
) (
  input  logic [WORD_W-1:0]   word,
  input  fu_vec_t             vec,
  output logic [FIELD_W-1:0]  bits,
  output logic [FU_LEN_W-1:0] len
);
  localparam int POS_W = $clog2(WORD_W) + 2;

  assign len = FU_LEN_W'(vec.len_m1) + FU_LEN_W'(1);

  for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
    logic [POS_W-1:0] pos;
    logic             in_len;
    // Unsigned wrap of a negative position lands far above WORD_W
    assign pos = vec.msb_first ? (POS_W'(vec.start) - POS_W'(k))
                               : (POS_W'(vec.start) + POS_W'(k));
    assign in_len = (k <= int'(vec.len_m1));
    always_comb begin
      bits[k] = 1'b0;
      if (in_len && pos < POS_W'(WORD_W))
        bits[k] = word[pos[$clog2(WORD_W)-1:0]];
    end
  end
endmodule

// File: rtl/fu_op_sequencer.sv
module fu_op_sequencer
  import fu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FU_WORD_W-1:0]    in_word,
  output logic [FU_WORD_W-1:0]    word_q,
  output logic [FU_OP_W-1:0]      op_idx,
  output logic                    busy,
  input  logic                    cur_stop,
  input  logic [FU_FIELD_W-1:0]   cur_bits,
  input  logic [FU_LEN_W-1:0]     cur_len,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [FU_FIELD_W-1:0]   out_bits,
  output logic [FU_LEN_W-1:0]     out_len,
  output logic                    out_last
);
  logic issue, final_op;

  assign in_ready = !busy;
  assign issue    = busy && (!out_valid || out_ready);
  assign final_op = cur_stop || (op_idx == FU_OP_W'(FU_NUM_OPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      op_idx    <= '0;
      word_q    <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_len   <= '0;
      out_last  <= 1'b0;
    end else begin
      if (in_valid && !busy) begin
        word_q <= in_word;
        busy   <= 1'b1;
        op_idx <= '0;
      end
      if (out_valid && out_ready)
        out_valid <= 1'b0;
      if (issue) begin
        out_valid <= 1'b1;
        out_bits  <= cur_bits;
        out_len   <= cur_len;
        out_last  <= final_op;
        if (final_op) begin
          busy   <= 1'b0;
          op_idx <= '0;
        end else begin
          op_idx <= op_idx + FU_OP_W'(1);
        end
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits)
      && $stable(out_len) && $stable(out_last))); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= FU_LEN_W'(1) && out_len <= FU_LEN_W'(FU_FIELD_W))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_bits >> out_len) == '0)); // R5
endmodule

// File: rtl/fifo_field_unpacker.sv
module fifo_field_unpacker
  import fu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [1:0]  gran_code,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_bits,
  output logic [3:0]  out_len,
  output logic        out_last
);
  logic [FU_NUM_OPS*FU_VEC_W-1:0] vec_flat;
  logic [FU_WORD_W-1:0]           word_q;
  logic [FU_OP_W-1:0]             op_idx;
  logic                           busy;
  fu_vec_t                        cur_vec;
  logic [FU_FIELD_W-1:0]          cur_bits;
  logic [FU_LEN_W-1:0]            cur_len;

  fu_cfg_bank u_cfg (
    .clk(clk), .rst(rst), .busy(busy), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .vec_flat(vec_flat), .gran_q(gran_code)
  );

  assign cur_vec = fu_vec_t'(vec_flat[op_idx*FU_VEC_W +: FU_VEC_W]);

  fu_field_extract #(.WORD_W(FU_WORD_W), .FIELD_W(FU_FIELD_W)) u_ext (
    .word(word_q), .vec(cur_vec), .bits(cur_bits), .len(cur_len)
  );

  fu_op_sequencer u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .word_q(word_q), .op_idx(op_idx), .busy(busy),
    .cur_stop(cur_vec.stop), .cur_bits(cur_bits), .cur_len(cur_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
    .out_len(out_len), .out_last(out_last)
  );

  // Fields handed over since the last end-of-word marker
  logic [FU_OP_W:0] sent_cnt;
  always_ff @(posedge clk) begin
    if (rst)
      sent_cnt <= '0;
    else if (out_valid && out_ready)
      sent_cnt <= out_last ? '0 : sent_cnt + 1'b1;
  end

  AST_FOURTH_IS_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sent_cnt < (FU_OP_W+1)'(FU_NUM_OPS - 1) || out_last)); // R7
endmodule

// File: tb/sim_fifo_field_unpacker.sv
`timescale 1ns/1ps
module sim_fifo_field_unpacker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, cfg_we, in_valid, out_ready, in_ready, out_valid, out_last;
  logic [1:0]  cfg_sel, gran_code;
  logic [31:0] cfg_wdata, in_word;
  logic [7:0]  out_bits;
  logic [3:0]  out_len;

  fifo_field_unpacker u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .gran_code(gran_code), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
    .out_len(out_len), .out_last(out_last)
  );

  int n_checks = 0, n_errs = 0;
  bit done = 0;
  logic [9:0] shadow [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int s, input int d, input int l, input int st);
    return {s[4:0], d[0], l[2:0], st[0]};
  endfunction

  // Reference field from the requirement text
  function automatic logic [7:0] ref_bits(input logic [9:0] v, input logic [31:0] w);
    logic [7:0] r = '0;
    int s = int'(v[9:5]);
    int lm = int'(v[3:1]);
    for (int k = 0; k < 8; k++) begin
      int p = v[4] ? s - k : s + k;
      if (k <= lm && p >= 0 && p < 32) r[k] = w[p];
    end
    return r;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d, input bit takes);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (takes && sel < 2) begin
      shadow[sel*2]   = d[9:0];
      shadow[sel*2+1] = d[19:10];
    end
  endtask

  task automatic load_vecs(input logic [9:0] a, b, c, e);
    cfg_write(2'd0, {12'd0, b, a}, 1);
    cfg_write(2'd1, {12'd0, e, c}, 1);
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1; in_word = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  // Collect the fields of one word and compare with the shadow program
  task automatic collect(input logic [31:0] w, input string req, input bit sample_now);
    int op = 0;
    bit fin = 0;
    bit first = sample_now;
    for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
      if (!first) @(negedge clk);
      first = 0;
      if (out_valid) begin
        logic [7:0] eb = ref_bits(shadow[op], w);
        logic [3:0] el = 4'(shadow[op][3:1]) + 4'd1;
        bit elast = shadow[op][0] || op == 3;
        chk(out_bits == eb, req, $sformatf("op%0d bits", op), 32'(out_bits), 32'(eb));
        chk(out_len == el && out_last == elast, req, $sformatf("op%0d len/last", op),
            {27'd0, out_last, out_len}, {27'd0, elast, el});
        fin = elast;
        op++;
      end
    end
    chk(fin, req, "word completed", 32'(fin), 32'd1);
  endtask

  task automatic run_word(input logic [31:0] w, input string req);
    push_word(w);
    collect(w, req, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1", "ready/valid after reset",
        {30'd0, in_ready, out_valid}, 32'd2);
    chk(gran_code == 0, "R1", "gran after reset", 32'(gran_code), 32'd0);
    for (int i = 0; i < 4; i++) shadow[i] = mk(i*8, 0, 7, i == 3);
    run_word(32'hA1B2C3D4, "R1");
  endtask

  task automatic t_seven_msb;
    load_vecs(mk(6,1,6,0), mk(14,1,6,0), mk(22,1,6,0), mk(30,1,6,1));
    run_word(32'h7F01557A, "R3");
    run_word(32'h12345678, "R2");
  endtask

  task automatic t_fifteen_lsb;
    load_vecs(mk(0,0,7,0), mk(8,0,6,0), mk(16,0,7,0), mk(24,0,6,1));
    run_word(32'hDEADBEEF, "R4");
    run_word(32'h80FF7F00, "R5");
  endtask

  task automatic t_stop_early;
    load_vecs(mk(22,1,7,0), mk(14,1,7,0), mk(6,1,6,1), mk(0,1,0,0));
    run_word(32'h00C3A55A, "R6");
    run_word(32'h003C5AA5, "R6");
  endtask

  task automatic t_no_stop;
    load_vecs(mk(3,1,3,0), mk(7,1,3,0), mk(11,1,3,0), mk(15,1,3,0));
    run_word(32'h0000C96E, "R7");
  endtask

  task automatic t_out_of_range;
    load_vecs(mk(30,0,7,0), mk(2,1,7,0), mk(31,1,0,0), mk(0,0,0,1));
    run_word(32'hFFFFFFFF, "R12");
  endtask

  task automatic t_gran;
    cfg_write(2'd2, 32'h0000_0002, 1);
    chk(gran_code == 2, "R11", "gran after idle write", 32'(gran_code), 32'd2);
    cfg_write(2'd2, 32'hFFFF_FFF1, 1);
    chk(gran_code == 1, "R11", "gran low bits only", 32'(gran_code), 32'd1);
  endtask

  task automatic t_backpressure_and_busy_cfg;
    logic [7:0] held;
    load_vecs(mk(0,0,7,0), mk(8,0,7,0), mk(16,0,7,0), mk(24,0,7,1));
    out_ready = 0;
    push_word(32'h44332211);
    @(negedge clk);
    chk(out_valid == 1, "R9", "first field valid", 32'(out_valid), 32'd1);
    held = out_bits;
    chk(in_ready == 0, "R8", "not ready while busy", 32'(in_ready), 32'd0);
    // Writes while a word is held must be dropped
    cfg_write(2'd0, {12'd0, mk(31,1,7,1), mk(31,1,7,1)}, 0);
    cfg_write(2'd2, 32'h3, 0);
    chk(gran_code == 1, "R10", "gran unchanged while busy", 32'(gran_code), 32'd1);
    chk(out_valid == 1 && out_bits == held, "R9", "held field stable",
        {23'd0, out_valid, out_bits}, {23'd0, 1'b1, held});
    out_ready = 1;
    collect(32'h44332211, "R10", 1);
    run_word(32'h88776655, "R10");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    in_valid = 0; in_word = 0; out_ready = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset;
    t_seven_msb;
    t_fifteen_lsb;
    t_stop_early;
    t_no_stop;
    t_out_of_range;
    t_gran;
    t_backpressure_and_busy_cfg;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule